// File: doc/BRIEF.md
# Dual-Port Shared Word Store with Collision Arbitration

This block is a clocked two-port word memory in which a left port and a right port each read and write any word on their own. Each port has an active-low select, a write strobe, an output enable and two byte-lane strobes. When both ports select the same word in the same cycle, an arbiter chooses one of them. The losing port is flagged on an active-low busy output one cycle later, and a write from the losing port is dropped.

A mode input sets the role of the device. As the master, the device arbitrates by itself and drives its busy outputs. As a slave, its busy outputs stay inactive and it takes the busy decision from its busy inputs instead. This lets the busy lines of one master feed several slaves that sit side by side and form a wider word. Read data is registered, so it comes out one cycle after the read is accepted, and the output enable only decides whether that word is shown.

Top module: `dual_port_arbiter`

## Requirements
- R1: After reset both busy outputs are high, both read-valid outputs are low and both read-data buses are zero.
- R2: A write (select low, write strobe low) stores bits 15:8 when the upper-lane strobe is low and bits 7:0 when the lower-lane strobe is low. A lane whose strobe is high keeps its old contents, so a write with both strobes high changes nothing.
- R3: A read (select low, write strobe high) presents the addressed word and raises read-valid in the cycle after it is accepted. If the other port writes that word in the same cycle, the read returns the value from before the write.
- R4: While a port's output enable is high, its read-valid is low and its read-data bus is zero.
- R5: A port whose select is high writes nothing, and its read-valid is low in the next cycle.
- R6: In master mode, when both ports newly select the same word in one cycle, the left port wins. The right busy output goes low in the next cycle and the right port's write is dropped.
- R7: In master mode, a port that selected a word in the previous cycle keeps priority when the other port arrives at that word. The newcomer is flagged busy, its write is dropped, and the winner stays the same for as long as the collision lasts.
- R8: In master mode, busy is high again in the cycle after the addresses differ or either port deselects, and the two busy outputs are never low together.
- R9: In slave mode, both busy outputs stay high. A port whose busy input is low at the clock edge has its write dropped. Writes from both ports to one word in one cycle leave the left port's data.
- R10: In master mode the busy inputs have no effect on writes.
- R11: Both ports may read the same word in one cycle, and both get its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 = arbitrate internally and drive busy; 0 = take busy from inputs |
| csNL | input | 1 | Left select, active low |
| weNL | input | 1 | Left write strobe, active low (high = read) |
| oeNL | input | 1 | Left output enable, active low |
| ubNL | input | 1 | Left upper-lane strobe, active low |
| lbNL | input | 1 | Left lower-lane strobe, active low |
| addrL | input | ADDR_W | Left word address |
| wdataL | input | 2*LANE_W | Left write data |
| rdataL | output | 2*LANE_W | Left read data, zero unless valid and enabled |
| rvalidL | output | 1 | Left read data valid |
| busyInNL | input | 1 | Left busy input, slave mode, active low |
| busyOutNL | output | 1 | Left busy output, master mode, active low |
| csNR | input | 1 | Right select, active low |
| weNR | input | 1 | Right write strobe, active low (high = read) |
| oeNR | input | 1 | Right output enable, active low |
| ubNR | input | 1 | Right upper-lane strobe, active low |
| lbNR | input | 1 | Right lower-lane strobe, active low |
| addrR | input | ADDR_W | Right word address |
| wdataR | input | 2*LANE_W | Right write data |
| rdataR | output | 2*LANE_W | Right read data, zero unless valid and enabled |
| rvalidR | output | 1 | Right read data valid |
| busyInNR | input | 1 | Right busy input, slave mode, active low |
| busyOutNR | output | 1 | Right busy output, master mode, active low |

## Verification
The bench builds the block with ADDR_W=6 and LANE_W=8, which gives 64 sixteen-bit words. With so few words, every word can be given a known value at the start. Random traffic is mostly held to four addresses, so same-cycle collisions, incumbents holding a word across cycles, and reads that meet writes all happen often. The random traffic runs in both modes, with random busy inputs in slave mode.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  // Per-port strobes from the control unit to the storage datapath.
  typedef struct packed {
    logic       wr;     // write accepted this cycle
    logic [1:0] lanes;  // [1] = upper lane, [0] = lower lane
    logic       rd;     // read accepted this cycle
  } portStrobe_t;

  typedef struct packed {
    portStrobe_t lft;
    portStrobe_t rgt;
  } ctlStrobe_t;
endpackage

// File: rtl/dpa_ctrl.sv
module dpa_ctrl
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              csNL,
  input  logic              weNL,
  input  logic              ubNL,
  input  logic              lbNL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              busyInNL,
  input  logic              csNR,
  input  logic              weNR,
  input  logic              ubNR,
  input  logic              lbNR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              busyInNR,
  output ctlStrobe_t        strobe,
  output logic              busyOutNL,
  output logic              busyOutNR
);
  logic selL, selR, collide, heldL, heldR, rgtWins, loseL, loseR;
  logic prevSelL, prevSelR, prevRgtWins;
  logic [ADDR_W-1:0] prevAddrL, prevAddrR;

  always_comb begin
    selL    = !csNL;
    selR    = !csNR;
    collide = selL && selR && (addrL == addrR);
    // A port is the incumbent if it was on this same word last cycle.
    heldL   = prevSelL && (prevAddrL == addrL);
    heldR   = prevSelR && (prevAddrR == addrR);
    if (!collide)            rgtWins = 1'b0;
    else if (heldL && heldR) rgtWins = prevRgtWins;
    else                     rgtWins = heldR && !heldL;
    if (isMaster) begin
      loseL = collide && rgtWins;
      loseR = collide && !rgtWins;
    end else begin
      loseL = !busyInNL;
      loseR = !busyInNR;
    end
    strobe.lft.wr    = selL && !weNL && !loseL;
    strobe.lft.lanes = {!ubNL, !lbNL};
    strobe.lft.rd    = selL && weNL;
    strobe.rgt.wr    = selR && !weNR && !loseR;
    strobe.rgt.lanes = {!ubNR, !lbNR};
    strobe.rgt.rd    = selR && weNR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSelL    <= 1'b0;
      prevSelR    <= 1'b0;
      prevAddrL   <= '0;
      prevAddrR   <= '0;
      prevRgtWins <= 1'b0;
      busyOutNL   <= 1'b1;
      busyOutNR   <= 1'b1;
    end else begin
      prevSelL    <= selL;
      prevSelR    <= selR;
      prevAddrL   <= addrL;
      prevAddrR   <= addrR;
      prevRgtWins <= rgtWins;
      busyOutNL   <= !(isMaster && collide && rgtWins);
      busyOutNR   <= !(isMaster && collide && !rgtWins);
    end
  end
endmodule

// File: rtl/dpa_store.sv
module dpa_store
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   addrL,
  input  logic [ADDR_W-1:0]   addrR,
  input  logic [2*LANE_W-1:0] wdataL,
  input  logic [2*LANE_W-1:0] wdataR,
  input  logic                oeNL,
  input  logic                oeNR,
  output logic [2*LANE_W-1:0] rdataL,
  output logic [2*LANE_W-1:0] rdataR,
  output logic                rvalidL,
  output logic                rvalidR
);
  localparam int LANES  = 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] wordL, wordR;
  logic rdDoneL, rdDoneR;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] qL, qR;
    always_ff @(posedge clk) begin
      // Right first, left last: the left port's data stays on a tie.
      if (strobe.rgt.wr && strobe.rgt.lanes[g])
        laneMem[addrR] <= wdataR[g*LANE_W +: LANE_W];
      if (strobe.lft.wr && strobe.lft.lanes[g])
        laneMem[addrL] <= wdataL[g*LANE_W +: LANE_W];
      if (strobe.lft.rd) qL <= laneMem[addrL];
      if (strobe.rgt.rd) qR <= laneMem[addrR];
    end
    assign wordL[g*LANE_W +: LANE_W] = qL;
    assign wordR[g*LANE_W +: LANE_W] = qR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDoneL <= 1'b0;
      rdDoneR <= 1'b0;
    end else begin
      rdDoneL <= strobe.lft.rd;
      rdDoneR <= strobe.rgt.rd;
    end
  end

  always_comb begin
    rvalidL = rdDoneL && !oeNL;
    rvalidR = rdDoneR && !oeNR;
    rdataL  = rvalidL ? wordL : '0;
    rdataR  = rvalidR ? wordR : '0;
  end
endmodule

// File: rtl/dual_port_arbiter.sv
module dual_port_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                isMaster,
  input  logic                csNL,
  input  logic                weNL,
  input  logic                oeNL,
  input  logic                ubNL,
  input  logic                lbNL,
  input  logic [ADDR_W-1:0]   addrL,
  input  logic [2*LANE_W-1:0] wdataL,
  output logic [2*LANE_W-1:0] rdataL,
  output logic                rvalidL,
  input  logic                busyInNL,
  output logic                busyOutNL,
  input  logic                csNR,
  input  logic                weNR,
  input  logic                oeNR,
  input  logic                ubNR,
  input  logic                lbNR,
  input  logic [ADDR_W-1:0]   addrR,
  input  logic [2*LANE_W-1:0] wdataR,
  output logic [2*LANE_W-1:0] rdataR,
  output logic                rvalidR,
  input  logic                busyInNR,
  output logic                busyOutNR
);
  ctlStrobe_t strobe;

  dpa_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .csNL(csNL), .weNL(weNL), .ubNL(ubNL), .lbNL(lbNL), .addrL(addrL), .busyInNL(busyInNL),
    .csNR(csNR), .weNR(weNR), .ubNR(ubNR), .lbNR(lbNR), .addrR(addrR), .busyInNR(busyInNR),
    .strobe(strobe), .busyOutNL(busyOutNL), .busyOutNR(busyOutNR)
  );

  dpa_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .addrL(addrL), .addrR(addrR), .wdataL(wdataL), .wdataR(wdataR),
    .oeNL(oeNL), .oeNR(oeNR),
    .rdataL(rdataL), .rdataR(rdataR), .rvalidL(rvalidL), .rvalidR(rvalidR)
  );
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                isMaster,
  input logic                csNL,
  input logic                weNL,
  input logic                oeNL,
  input logic [ADDR_W-1:0]   addrL,
  input logic [2*LANE_W-1:0] rdataL,
  input logic                rvalidL,
  input logic                busyOutNL,
  input logic                csNR,
  input logic                oeNR,
  input logic [ADDR_W-1:0]   addrR,
  input logic [2*LANE_W-1:0] rdataR,
  input logic                rvalidR,
  input logic                busyOutNR
);
  logic sameWord;
  assign sameWord = !csNL && !csNR && (addrL == addrR);

  // R8: never both ports flagged
  p_busy_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyOutNL && !busyOutNR));

  // R8: release after the addresses part
  p_busy_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !sameWord) |=> (busyOutNL && busyOutNR));

  // R6: fresh collision, right not incumbent, so left wins
  p_left_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && sameWord && !(!$past(csNR) && $past(addrR) == addrR))
      |=> (busyOutNL && !busyOutNR));

  // R7: right incumbent, left newcomer, so left is flagged
  p_incumbent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && sameWord && !$past(csNR) && $past(addrR) == addrR
      && !(!$past(csNL) && $past(addrL) == addrL)) |=> !busyOutNL);

  // R9: slave keeps busy outputs inactive
  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |=> (busyOutNL && busyOutNR));

  // R3: accepted read shows up one cycle later when enabled
  p_read_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!csNL && weNL) |=> (rvalidL == !oeNL));

  // R4: output enable high blanks the bus
  p_oe_blank_r4: assert property (@(posedge clk) disable iff (!rstN)
    oeNR |-> (!rvalidR && rdataR == '0));

  // R5: deselected port has no read the next cycle
  p_desel_r5: assert property (@(posedge clk) disable iff (!rstN)
    csNL |=> !rvalidL);

  // R4: left side as well
  p_oe_blank_left_r4: assert property (@(posedge clk) disable iff (!rstN)
    oeNL |-> (!rvalidL && rdataL == '0));
endmodule

bind dual_port_arbiter dpa_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster),
  .csNL(csNL), .weNL(weNL), .oeNL(oeNL), .addrL(addrL), .rdataL(rdataL),
  .rvalidL(rvalidL), .busyOutNL(busyOutNL),
  .csNR(csNR), .oeNR(oeNR), .addrR(addrR), .rdataR(rdataR),
  .rvalidR(rvalidR), .busyOutNR(busyOutNR)
);

// File: tb/tb_dual_port_arbiter.sv
module tb_dual_port_arbiter;
  localparam int PERIOD = 10;
  localparam int AW     = 6;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b1;
  logic csN [2];
  logic weN [2];
  logic oeN [2];
  logic ubN [2];
  logic lbN [2];
  logic bIn [2];
  logic [AW-1:0] addr [2];
  logic [15:0]   wdat [2];
  logic [15:0] rdataL, rdataR;
  logic rvalidL, rvalidR, busyOutNL, busyOutNR;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [15:0]   mMem [DEPTH];
  logic [15:0]   mRd [2];
  logic          mRdv [2];
  logic          mBusy [2];
  logic          mPrevSel [2];
  logic [AW-1:0] mPrevAddr [2];
  logic          mPrevRw;

  always #(PERIOD/2) clk = ~clk;

  dual_port_arbiter #(.ADDR_W(AW), .LANE_W(8)) dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .csNL(csN[0]), .weNL(weN[0]), .oeNL(oeN[0]), .ubNL(ubN[0]), .lbNL(lbN[0]),
    .addrL(addr[0]), .wdataL(wdat[0]), .rdataL(rdataL), .rvalidL(rvalidL),
    .busyInNL(bIn[0]), .busyOutNL(busyOutNL),
    .csNR(csN[1]), .weNR(weN[1]), .oeNR(oeN[1]), .ubNR(ubN[1]), .lbNR(lbN[1]),
    .addrR(addr[1]), .wdataR(wdat[1]), .rdataR(rdataR), .rvalidR(rvalidR),
    .busyInNR(bIn[1]), .busyOutNR(busyOutNR)
  );

  function automatic logic [15:0] seedWord(int i);
    return 16'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setPort(int p, logic cs, logic we, logic oe, logic ub, logic lb,
                         logic [AW-1:0] a, logic [15:0] d);
    csN[p] = cs; weN[p] = we; oeN[p] = oe; ubN[p] = ub; lbN[p] = lb;
    addr[p] = a; wdat[p] = d;
  endtask

  task automatic idle();
    for (int p = 0; p < 2; p++) setPort(p, 1, 1, 0, 0, 0, '0, '0);
  endtask

  // One clock: update the model from the driven inputs, then compare all outputs.
  task automatic step(string tag);
    logic sel [2];
    logic col, h0, h1, rw;
    logic lose [2];
    @(posedge clk);
    sel[0] = !csN[0];
    sel[1] = !csN[1];
    col = sel[0] && sel[1] && (addr[0] == addr[1]);
    h0  = mPrevSel[0] && (mPrevAddr[0] == addr[0]);
    h1  = mPrevSel[1] && (mPrevAddr[1] == addr[1]);
    rw  = col && ((h0 && h1) ? mPrevRw : (h1 && !h0));
    lose[0] = isMaster ? (col && rw)  : !bIn[0];
    lose[1] = isMaster ? (col && !rw) : !bIn[1];
    for (int p = 0; p < 2; p++) begin
      mRdv[p] = sel[p] && weN[p];
      if (mRdv[p]) mRd[p] = mMem[addr[p]];
    end
    for (int p = 1; p >= 0; p--) begin
      if (sel[p] && !weN[p] && !lose[p]) begin
        if (!ubN[p]) mMem[addr[p]][15:8] = wdat[p][15:8];
        if (!lbN[p]) mMem[addr[p]][7:0]  = wdat[p][7:0];
      end
    end
    mBusy[0] = !(isMaster && col && rw);
    mBusy[1] = !(isMaster && col && !rw);
    for (int p = 0; p < 2; p++) begin
      mPrevSel[p]  = sel[p];
      mPrevAddr[p] = addr[p];
    end
    mPrevRw = rw;
    #1;
    chk({tag, " busyL"},  busyOutNL, mBusy[0]);
    chk({tag, " busyR"},  busyOutNR, mBusy[1]);
    chk({tag, " validL"}, rvalidL, mRdv[0] && !oeN[0]);
    chk({tag, " validR"}, rvalidR, mRdv[1] && !oeN[1]);
    chk({tag, " dataL"},  rdataL, (mRdv[0] && !oeN[0]) ? mRd[0] : 16'h0);
    chk({tag, " dataR"},  rdataR, (mRdv[1] && !oeN[1]) ? mRd[1] : 16'h0);
    @(negedge clk);
  endtask

  task automatic randPort(int p);
    logic [AW-1:0] a;
    a = ($urandom % 5 != 0) ? AW'($urandom % 4) : AW'($urandom % DEPTH);
    setPort(p, ($urandom % 5 == 0), $urandom % 2, ($urandom % 4 == 0),
            ($urandom % 3 == 0), ($urandom % 3 == 0), a, 16'($urandom));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle();
    bIn[0] = 1; bIn[1] = 1;
    for (int p = 0; p < 2; p++) begin
      mRdv[p] = 0; mBusy[p] = 1; mPrevSel[p] = 0; mPrevAddr[p] = '0; mRd[p] = '0;
    end
    mPrevRw = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 busyL", busyOutNL, 1'b1);
    chk("R1 busyR", busyOutNR, 1'b1);
    chk("R1 validL", rvalidL, 1'b0);
    chk("R1 validR", rvalidR, 1'b0);
    chk("R1 dataL", rdataL, 16'h0);
    chk("R1 dataR", rdataR, 16'h0);
    @(negedge clk);

    // fill every word through the left port, full-word writes (R2)
    for (int i = 0; i < DEPTH; i++) begin
      setPort(0, 0, 0, 0, 0, 0, AW'(i), seedWord(i));
      step("R2 fill");
    end

    // R2: byte lanes
    idle(); setPort(0, 0, 0, 0, 0, 0, 6'd10, 16'hAAAA); step("R2 full");
    setPort(0, 0, 0, 0, 0, 1, 6'd10, 16'h1234); step("R2 upper");
    setPort(0, 0, 0, 0, 1, 0, 6'd10, 16'h5678); step("R2 lower");
    setPort(0, 0, 0, 0, 1, 1, 6'd10, 16'hFFFF); step("R2 none");
    setPort(0, 0, 1, 0, 0, 0, 6'd10, 16'h0);    step("R2 read");
    chk("R2 lanes merged", rdataL, 16'h1278);

    // R4: output enable high blanks the read
    setPort(0, 0, 1, 1, 0, 0, 6'd10, 16'h0); step("R4");
    chk("R4 valid", rvalidL, 1'b0);
    chk("R4 data", rdataL, 16'h0);

    // R5: deselected write has no effect, no read-valid next
    setPort(0, 1, 0, 0, 0, 0, 6'd10, 16'h0000); step("R5 desel");
    chk("R5 valid", rvalidL, 1'b0);
    setPort(0, 0, 1, 0, 0, 0, 6'd10, 16'h0); step("R5 read");
    chk("R5 unchanged", rdataL, 16'h1278);

    // R6: fresh same-cycle collision, left wins
    idle(); step("R6 gap");
    setPort(0, 0, 0, 0, 0, 0, 6'd20, 16'h1111);
    setPort(1, 0, 0, 0, 0, 0, 6'd20, 16'h2222);
    step("R6 collide");
    chk("R6 busyR low", busyOutNR, 1'b0);
    chk("R6 busyL high", busyOutNL, 1'b1);
    idle(); step("R8 release");
    chk("R8 busyR released", busyOutNR, 1'b1);
    setPort(0, 0, 1, 0, 0, 0, 6'd20, 16'h0); step("R6 read");
    chk("R6 winner data", rdataL, 16'h1111);

    // R7: incumbent right keeps priority over arriving left writer
    idle(); step("R7 gap");
    setPort(1, 0, 1, 0, 0, 0, 6'd30, 16'h0); step("R7 right alone");
    setPort(0, 0, 0, 0, 0, 0, 6'd30, 16'hBEEF); step("R7 left arrives");
    chk("R7 busyL low", busyOutNL, 1'b0);
    chk("R7 busyR high", busyOutNR, 1'b1);
    step("R7 held");
    chk("R7 still left busy", busyOutNL, 1'b0);
    setPort(1, 1, 1, 0, 0, 0, 6'd0, 16'h0);
    setPort(0, 0, 1, 0, 0, 0, 6'd30, 16'h0); step("R8 deselect");
    chk("R8 busyL released", busyOutNL, 1'b1);
    chk("R7 write dropped", rdataL, seedWord(30));

    // R11: both read one word
    idle(); step("R11 gap");
    setPort(0, 0, 1, 0, 0, 0, 6'd40, 16'h0);
    setPort(1, 0, 1, 0, 0, 0, 6'd40, 16'h0);
    step("R11 dual read");
    chk("R11 left", rdataL, seedWord(40));
    chk("R11 right", rdataR, seedWord(40));

    // R10: master ignores busy inputs
    idle(); bIn[0] = 0; bIn[1] = 0;
    setPort(0, 0, 0, 0, 0, 0, 6'd41, 16'h4141); step("R10 write");
    setPort(0, 0, 1, 0, 0, 0, 6'd41, 16'h0);    step("R10 read");
    chk("R10 landed", rdataL, 16'h4141);

    // R9: slave mode
    idle(); isMaster = 0; bIn[0] = 0; bIn[1] = 1;
    setPort(0, 0, 0, 0, 0, 0, 6'd42, 16'h4242); step("R9 blocked");
    chk("R9 busyL high", busyOutNL, 1'b1);
    setPort(0, 0, 1, 0, 0, 0, 6'd42, 16'h0); step("R9 read");
    chk("R9 suppressed", rdataL, seedWord(42));
    bIn[0] = 1;
    setPort(0, 0, 0, 0, 0, 0, 6'd43, 16'hAAAA);
    setPort(1, 0, 0, 0, 0, 0, 6'd43, 16'h5555);
    step("R9 tie");
    chk("R9 busyR high", busyOutNR, 1'b1);
    idle();
    setPort(0, 0, 1, 0, 0, 0, 6'd43, 16'h0); step("R9 tie read");
    chk("R9 left kept", rdataL, 16'hAAAA);

    // R3: read meets same-cycle write from the other port
    setPort(0, 0, 1, 0, 0, 0, 6'd44, 16'h0);
    setPort(1, 0, 0, 0, 0, 0, 6'd44, 16'h9999);
    step("R3 read old");
    chk("R3 old data", rdataL, seedWord(44));
    idle();
    setPort(0, 0, 1, 0, 0, 0, 6'd44, 16'h0); step("R3 read new");
    chk("R3 new data", rdataL, 16'h9999);

    // random traffic, master mode (R6 R7 R8)
    isMaster = 1;
    for (int n = 0; n < 1500; n++) begin
      randPort(0); randPort(1);
      bIn[0] = $urandom % 2; bIn[1] = $urandom % 2;
      step("R8 rand master");
    end
    // random traffic, slave mode (R9)
    isMaster = 0;
    for (int n = 0; n < 600; n++) begin
      randPort(0); randPort(1);
      bIn[0] = ($urandom % 4 != 0); bIn[1] = ($urandom % 4 != 0);
      step("R9 rand slave");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule